// File: doc/BRIEF.md
# Sixty-Four-Bit Global Timer with Self-Rearming Comparator

This block keeps a free-running 64-bit up-counter and one comparator behind a simple 32-bit register port. Software starts and stops the counter, reads or loads it as two 32-bit halves, and programs a 64-bit compare value. When the comparator is enabled and the counter equals the compare value, a sticky interrupt status bit sets. The interrupt output is high while that bit and its enable are both set.

In periodic mode, each match adds a programmed 32-bit step to the compare value. The interrupt then recurs every step-count clocks without any further software action. In one-shot mode the compare value stays where it was. Each write to the counter, comparator, step or control register is confirmed by a sticky write-status bit. Software clears that bit by writing 1 to it.

The register port is a single-cycle write strobe with an address and data. Reads return data combinationally while the read strobe is high, or one cycle later when the block is built with a registered read path.

Top module: `gtimer_cmp`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Offsets 0x100 and 0x104 read and load the low and high counter halves. While control bit 8 is set, the counter advances by one per clock, starting on the edge after the control write. While bit 8 is clear, the counter holds.
- R3: The low half carries into the high half. Reading the high half, then the low half, then the high half again gives a consistent 64-bit value whenever the two high reads agree.
- R4: While control bit 0 is set, equality of the counter with the 64-bit compare value (0x200 low, 0x204 high) sets status bit 0 at 0x244 on the following edge. While control bit 0 is clear, the status bit never sets.
- R5: With control bit 1 clear, a match leaves the compare value unchanged. The status bit stays set until software writes 1 to bit 0 of 0x244.
- R6: With control bits 1 and 0 both set, every match adds the step register at 0x208 to the compare value on the same edge that sets the status bit.
- R7: `irq` equals status bit 0 at 0x244 ANDed with enable bit 0 at 0x248.
- R8: Register 0x110 sets bit 0 after a low-counter write and bit 1 after a high-counter write. Each bit sets one edge after the update and is cleared by writing 1 to it.
- R9: Register 0x24C sets bit 0, 1 or 2 after a write to 0x200, 0x204 or 0x208, and bit 16 after a write to 0x240. Each bit sets one edge after the update, and each is cleared individually by writing 1 to it.
- R10: When a write-status bit is being set and cleared on the same edge, the set wins.
- R11: The control register at 0x240 stores only bits 8, 1 and 0. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one register write per cycle |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data; zero while no read is requested |
| irq | output | 1 | Level interrupt from the comparator |

## Verification
The bench builds the block with its defaults: 32-bit data, a 12-bit address and the combinational read path. With the combinational read path, the bench can sample any register between two clock edges without spending a cycle. That makes the exact edge of each status set, compare advance and counter step directly observable. The counter is preloaded just below the low-half wrap, so the carry into the high half and the high-low-high read are reached within a few clocks.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
   // register offsets (software-visible map)
   localparam int unsigned OFS_CNT_LO = 'h100;
   localparam int unsigned OFS_CNT_HI = 'h104;
   localparam int unsigned OFS_CNT_WS = 'h110;
   localparam int unsigned OFS_CMP_LO = 'h200;
   localparam int unsigned OFS_CMP_HI = 'h204;
   localparam int unsigned OFS_STEP   = 'h208;
   localparam int unsigned OFS_CTL    = 'h240;
   localparam int unsigned OFS_ISTAT  = 'h244;
   localparam int unsigned OFS_IEN    = 'h248;
   localparam int unsigned OFS_WS     = 'h24C;

   // control bit positions
   localparam int unsigned CTL_RUN_BIT  = 8;
   localparam int unsigned CTL_AUTO_BIT = 1;
   localparam int unsigned CTL_CEN_BIT  = 0;

   // write-status bit for control writes in the main status word
   localparam int unsigned WS_CTL_BIT = 16;

   typedef struct packed {
      logic run;
      logic auto_inc;
      logic cmp_en;
   } ctl_t;
endpackage

// File: rtl/gtc_w1c.sv
module gtc_w1c #(
   parameter int unsigned NBITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] set_req,
   input  logic [NBITS-1:0] clr_req,
   output logic [NBITS-1:0] bits
);
   logic [NBITS-1:0] set_d;

   generate
      for (genvar i = 0; i < NBITS; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               set_d[i] <= 1'b0;
               bits[i]  <= 1'b0;
            end else begin
               set_d[i] <= set_req[i];
               if (set_d[i])
                  bits[i] <= 1'b1;
               else if (clr_req[i])
                  bits[i] <= 1'b0;
            end
         end

         AST_WS_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_req[i] |-> ##2 bits[i]); // R10
      end
   endgenerate
endmodule

// File: rtl/gtc_counter.sv
module gtc_counter #(
   parameter int unsigned DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                wr_lo,
   input  logic                wr_hi,
   input  logic [DATA_W-1:0]   wdata,
   output logic [2*DATA_W-1:0] cnt
);
   localparam int unsigned CNT_W = 2 * DATA_W;

   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      cnt_nxt = run ? cnt + CNT_W'(1) : cnt;
      if (wr_lo) cnt_nxt[DATA_W-1:0]      = wdata;
      if (wr_hi) cnt_nxt[CNT_W-1:DATA_W]  = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wr_lo && !wr_hi) |=> (cnt == $past(cnt) + CNT_W'(1))); // R2
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_lo && !wr_hi) |=> $stable(cnt)); // R2
endmodule

// File: rtl/gtc_compare.sv
module gtc_compare #(
   parameter int unsigned DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*DATA_W-1:0] cnt,
   input  logic                cmp_en,
   input  logic                auto_inc,
   input  logic                wr_lo,
   input  logic                wr_hi,
   input  logic                wr_step,
   input  logic                clr_stat,
   input  logic [DATA_W-1:0]   wdata,
   output logic [2*DATA_W-1:0] cmp,
   output logic [DATA_W-1:0]   step,
   output logic                stat
);
   localparam int unsigned CNT_W = 2 * DATA_W;

   logic             hit;
   logic [CNT_W-1:0] cmp_nxt;

   assign hit = cmp_en && (cnt == cmp);

   always_comb begin
      cmp_nxt = (hit && auto_inc) ? cmp + {{DATA_W{1'b0}}, step} : cmp;
      if (wr_lo) cmp_nxt[DATA_W-1:0]     = wdata;
      if (wr_hi) cmp_nxt[CNT_W-1:DATA_W] = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp  <= '0;
         step <= '0;
         stat <= 1'b0;
      end else begin
         cmp <= cmp_nxt;
         if (wr_step) step <= wdata;
         if (hit)           stat <= 1'b1;
         else if (clr_stat) stat <= 1'b0;
      end
   end

   AST_HIT_SETS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && (cnt == cmp)) |=> stat); // R4
   AST_STAT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat) |-> $past(cmp_en && (cnt == cmp))); // R4
   AST_PERIODIC_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && auto_inc && (cnt == cmp) && !wr_lo && !wr_hi)
      |=> (cmp == $past(cmp) + {{DATA_W{1'b0}}, $past(step)})); // R6
   AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cmp_en && auto_inc) && !wr_lo && !wr_hi) |=> $stable(cmp)); // R5
endmodule

// File: rtl/gtimer_cmp.sv
module gtimer_cmp
   import gtc_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 12,
   parameter bit          RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int unsigned CNT_W = 2 * DATA_W;
   localparam int unsigned NWS   = 4;

   generate
      if (DATA_W <= WS_CTL_BIT) begin : g_bad_width
         $error("DATA_W must exceed the control write-status bit position");
      end
      if (ADDR_W < 10) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   // write decode
   logic wr_cnt_lo, wr_cnt_hi, wr_cnt_ws, wr_cmp_lo, wr_cmp_hi;
   logic wr_step, wr_ctl, wr_istat, wr_ien, wr_ws;

   assign wr_cnt_lo = reg_wr && (reg_addr == ADDR_W'(OFS_CNT_LO));
   assign wr_cnt_hi = reg_wr && (reg_addr == ADDR_W'(OFS_CNT_HI));
   assign wr_cnt_ws = reg_wr && (reg_addr == ADDR_W'(OFS_CNT_WS));
   assign wr_cmp_lo = reg_wr && (reg_addr == ADDR_W'(OFS_CMP_LO));
   assign wr_cmp_hi = reg_wr && (reg_addr == ADDR_W'(OFS_CMP_HI));
   assign wr_step   = reg_wr && (reg_addr == ADDR_W'(OFS_STEP));
   assign wr_ctl    = reg_wr && (reg_addr == ADDR_W'(OFS_CTL));
   assign wr_istat  = reg_wr && (reg_addr == ADDR_W'(OFS_ISTAT));
   assign wr_ien    = reg_wr && (reg_addr == ADDR_W'(OFS_IEN));
   assign wr_ws     = reg_wr && (reg_addr == ADDR_W'(OFS_WS));

   // control and interrupt enable
   ctl_t ctl_q;
   logic ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         ien_q <= 1'b0;
      end else begin
         if (wr_ctl) begin
            ctl_q.run      <= reg_wdata[CTL_RUN_BIT];
            ctl_q.auto_inc <= reg_wdata[CTL_AUTO_BIT];
            ctl_q.cmp_en   <= reg_wdata[CTL_CEN_BIT];
         end
         if (wr_ien) ien_q <= reg_wdata[0];
      end
   end

   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cmp;
   logic [DATA_W-1:0] step;
   logic              stat;

   gtc_counter #(.DATA_W(DATA_W)) i_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctl_q.run),
      .wr_lo (wr_cnt_lo),
      .wr_hi (wr_cnt_hi),
      .wdata (reg_wdata),
      .cnt   (cnt)
   );

   gtc_compare #(.DATA_W(DATA_W)) i_compare (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt),
      .cmp_en   (ctl_q.cmp_en),
      .auto_inc (ctl_q.auto_inc),
      .wr_lo    (wr_cmp_lo),
      .wr_hi    (wr_cmp_hi),
      .wr_step  (wr_step),
      .clr_stat (wr_istat && reg_wdata[0]),
      .wdata    (reg_wdata),
      .cmp      (cmp),
      .step     (step),
      .stat     (stat)
   );

   assign irq = stat && ien_q;

   // write-status words
   logic [1:0]     cnt_ws;
   logic [NWS-1:0] main_ws;

   gtc_w1c #(.NBITS(2)) i_cnt_ws (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req ({wr_cnt_hi, wr_cnt_lo}),
      .clr_req ({2{wr_cnt_ws}} & reg_wdata[1:0]),
      .bits    (cnt_ws)
   );

   gtc_w1c #(.NBITS(NWS)) i_main_ws (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req ({wr_ctl, wr_step, wr_cmp_hi, wr_cmp_lo}),
      .clr_req ({NWS{wr_ws}} & {reg_wdata[WS_CTL_BIT], reg_wdata[2:0]}),
      .bits    (main_ws)
   );

   // read mux
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (reg_addr == ADDR_W'(OFS_CNT_LO))      rd_mux = cnt[DATA_W-1:0];
      else if (reg_addr == ADDR_W'(OFS_CNT_HI)) rd_mux = cnt[CNT_W-1:DATA_W];
      else if (reg_addr == ADDR_W'(OFS_CNT_WS)) rd_mux[1:0] = cnt_ws;
      else if (reg_addr == ADDR_W'(OFS_CMP_LO)) rd_mux = cmp[DATA_W-1:0];
      else if (reg_addr == ADDR_W'(OFS_CMP_HI)) rd_mux = cmp[CNT_W-1:DATA_W];
      else if (reg_addr == ADDR_W'(OFS_STEP))   rd_mux = step;
      else if (reg_addr == ADDR_W'(OFS_CTL)) begin
         rd_mux[CTL_RUN_BIT]  = ctl_q.run;
         rd_mux[CTL_AUTO_BIT] = ctl_q.auto_inc;
         rd_mux[CTL_CEN_BIT]  = ctl_q.cmp_en;
      end
      else if (reg_addr == ADDR_W'(OFS_ISTAT))  rd_mux[0] = stat;
      else if (reg_addr == ADDR_W'(OFS_IEN))    rd_mux[0] = ien_q;
      else if (reg_addr == ADDR_W'(OFS_WS)) begin
         rd_mux[2:0]        = main_ws[2:0];
         rd_mux[WS_CTL_BIT] = main_ws[3];
      end
   end

   generate
      if (RD_REG) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      reg_rdata <= '0;
            else if (reg_rd) reg_rdata <= rd_mux;
            else             reg_rdata <= '0;
         end
      end else begin : g_rd_comb
         assign reg_rdata = reg_rd ? rd_mux : '0;
      end
   endgenerate

   AST_IRQ_OFF_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ien && !reg_wdata[0]) |=> !irq); // R7
endmodule

// File: tb/test_gtimer_cmp.sv
`timescale 1ns/100ps
module test_gtimer_cmp;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 12;

   localparam logic [AW-1:0] A_CLO = 'h100, A_CHI = 'h104, A_CWS = 'h110;
   localparam logic [AW-1:0] A_MLO = 'h200, A_MHI = 'h204, A_STP = 'h208;
   localparam logic [AW-1:0] A_CTL = 'h240, A_IST = 'h244, A_IEN = 'h248, A_WS = 'h24C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   gtimer_cmp #(.DATA_W(DW), .ADDR_W(AW)) i_gtimer_cmp (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a negedge; the write lands on the next posedge, returns at the negedge after it
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] d);
      reg_rd = 1'b1; reg_addr = a;
      #0.5;
      d = reg_rdata;
      reg_rd = 1'b0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      logic [AW-1:0] regs [10] = '{A_CLO, A_CHI, A_CWS, A_MLO, A_MHI, A_STP, A_CTL, A_IST, A_IEN, A_WS};
      for (int i = 0; i < 10; i++) begin
         peek(regs[i], v);
         chk("R1 reset register", v, '0);
      end
      chk("R1 reset irq", {31'b0, irq}, 32'd0);
   endtask

   task automatic t_wstat();
      logic [DW-1:0] v;
      wr(A_MLO, 32'h55); peek(A_WS, v); chk("R9 not yet set", v, 32'h0);
      step(); peek(A_WS, v); chk("R9 cmp lo bit0", v, 32'h1);
      wr(A_MHI, 32'h0); step(); peek(A_WS, v); chk("R9 cmp hi bit1", v, 32'h3);
      wr(A_STP, 32'h9); step(); peek(A_WS, v); chk("R9 step bit2", v, 32'h7);
      wr(A_CTL, 32'h0);
      wr(A_WS, 32'h1_0000);
      peek(A_WS, v); chk("R10 set beats clear", v, 32'h1_0007);
      wr(A_WS, 32'h2); peek(A_WS, v); chk("R9 clear bit1 only", v, 32'h1_0005);
      wr(A_WS, 32'h1_0005); peek(A_WS, v); chk("R9 clear rest", v, 32'h0);
   endtask

   task automatic t_counter();
      logic [DW-1:0] v;
      wr(A_CLO, 32'h1234_5678); peek(A_CWS, v); chk("R8 not yet set", v, 32'h0);
      step(); peek(A_CWS, v); chk("R8 lo bit0", v, 32'h1);
      wr(A_CHI, 32'hA5); step(); peek(A_CWS, v); chk("R8 hi bit1", v, 32'h3);
      peek(A_CLO, v); chk("R2 load lo", v, 32'h1234_5678);
      peek(A_CHI, v); chk("R2 load hi", v, 32'hA5);
      wr(A_CWS, 32'h1); peek(A_CWS, v); chk("R8 clear bit0", v, 32'h2);
      wr(A_CWS, 32'h2); peek(A_CWS, v); chk("R8 clear bit1", v, 32'h0);
      wr(A_CTL, 32'h100); peek(A_CLO, v); chk("R2 first edge no step", v, 32'h1234_5678);
      repeat (10) step();
      peek(A_CLO, v); chk("R2 ten steps", v, 32'h1234_5682);
      wr(A_CTL, 32'h0); peek(A_CLO, v); chk("R2 last step", v, 32'h1234_5683);
      repeat (5) step();
      peek(A_CLO, v); chk("R2 hold when stopped", v, 32'h1234_5683);
   endtask

   task automatic t_carry();
      logic [DW-1:0] v, h1, lo, h2;
      wr(A_CLO, 32'hFFFF_FFFC); wr(A_CHI, 32'h7);
      wr(A_CTL, 32'h100);
      peek(A_CHI, v); chk("R3 hi before wrap", v, 32'h7);
      repeat (3) step();
      peek(A_CLO, v); chk("R3 lo at top", v, 32'hFFFF_FFFF);
      step();
      peek(A_CHI, h1); peek(A_CLO, lo); peek(A_CHI, h2);
      chk("R3 hi agree", h1, h2);
      chk("R3 carried hi", h1, 32'h8);
      chk("R3 wrapped lo", lo, 32'h0);
      wr(A_CTL, 32'h0);
   endtask

   task automatic t_oneshot();
      logic [DW-1:0] v;
      wr(A_CLO, 0); wr(A_CHI, 0); wr(A_MLO, 20); wr(A_MHI, 0);
      wr(A_IEN, 1); wr(A_IST, 1);
      wr(A_CTL, 32'h101);
      for (int k = 1; k <= 24; k++) begin
         step();
         if (k == 20 || k == 21) begin
            peek(A_IST, v);
            chk("R4 status edge", v, (k >= 21) ? 32'h1 : 32'h0);
            chk("R7 irq follows status", {31'b0, irq}, (k >= 21) ? 32'h1 : 32'h0);
         end
      end
      peek(A_MLO, v); chk("R5 compare unchanged", v, 32'd20);
      repeat (5) step();
      peek(A_IST, v); chk("R5 status sticky", v, 32'h1);
      wr(A_IST, 1); peek(A_IST, v); chk("R5 status cleared", v, 32'h0);
      chk("R7 irq cleared", {31'b0, irq}, 32'h0);
      wr(A_IEN, 0); wr(A_CTL, 32'h1); wr(A_CLO, 20); step();
      peek(A_IST, v); chk("R4 held match sets", v, 32'h1);
      chk("R7 masked irq", {31'b0, irq}, 32'h0);
      wr(A_IEN, 1); chk("R7 unmasked irq", {31'b0, irq}, 32'h1);
      wr(A_CTL, 32'h0); wr(A_IST, 1);
      repeat (3) step();
      peek(A_IST, v); chk("R4 disabled never sets", v, 32'h0);
   endtask

   task automatic t_periodic();
      logic [DW-1:0] v;
      wr(A_CLO, 0); wr(A_CHI, 0); wr(A_MLO, 8); wr(A_MHI, 0); wr(A_STP, 5);
      wr(A_IST, 1);
      wr(A_CTL, 32'h103);
      for (int k = 1; k <= 20; k++) begin
         step();
         if (k == 8 || k == 9 || k == 13 || k == 14 || k == 19) begin
            peek(A_MLO, v);
            chk("R6 compare advance", v,
                32'd8 + 32'd5 * ((k >= 9 ? 1 : 0) + (k >= 14 ? 1 : 0) + (k >= 19 ? 1 : 0)));
         end
         if (k == 8) chk("R6 no irq before match", {31'b0, irq}, 32'h0);
         if (k == 9) chk("R6 irq at match", {31'b0, irq}, 32'h1);
      end
      peek(A_MHI, v); chk("R6 compare hi", v, 32'h0);
      wr(A_CTL, 32'h0); wr(A_IST, 1);
   endtask

   task automatic t_ctl_mask();
      logic [DW-1:0] v;
      wr(A_CTL, 32'hFFFF_FFFF);
      peek(A_CTL, v); chk("R11 control bits", v, 32'h103);
      wr(A_CTL, 32'h0);
      peek(A_CTL, v); chk("R11 control cleared", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_wstat();
      t_counter();
      t_carry();
      t_oneshot();
      t_periodic();
      t_ctl_mask();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule